// File: doc/BRIEF.md
# Interrupt Summary Status Collector

This block combines the interrupt requests of five framer sub-blocks into one 8-bit summary status register on a simple processor read bus. The five sources are a one-second timer, the data link (HDLC) controller, the slip buffer, the alarm and error monitor, and the framer status logic. A single-cycle pulse on any request input sets the matching summary bit. That bit stays set until the processor performs the read that acknowledges it.

The bits do not all clear in the same way. The one-second bit clears when the summary register itself is read. Each of the other four bits clears only when the processor reads the status register of its own sub-block. A service routine therefore reads the summary first to learn which sub-blocks need attention, then reads each of those sub-blocks' status registers. Those reads clear the matching summary bits.

The combined interrupt output is the OR of all summary bits. It stays asserted until every pending bit has been acknowledged.

Top module: `intStatusAgg`

## Requirements
- R1: After reset all five summary bits are 0, the interrupt output is 0, and a read of the summary register returns 0x00.
- R2: A pulse on `evtOneSec` sets summary bit 4. The bit reads 1 until a read of the summary address (default 0x0B00) clears it. A summary read clears no other bit.
- R3: A pulse on `reqHdlc` sets bit 3. The bit clears only on a read of the data link status address (default 0x0A06).
- R4: A pulse on `reqSlip` sets bit 2. The bit clears only on a read of the slip status address (default 0x0A09).
- R5: A pulse on `reqAlarm` sets bit 1. The bit clears only on a read of the alarm status address (default 0x0A02).
- R6: A pulse on `reqFrame` sets bit 0. The bit clears only on a read of the framer status address, which is a parameter with default 0x0A04.
- R7: Bits 7 to 5 of the summary read data are always 0.
- R8: If a request pulse arrives in the same cycle as the read that clears its bit, the bit remains 1 afterwards.
- R9: `irqOut` is 1 exactly when at least one summary bit is 1. It falls only in the cycle after a clearing read.
- R10: `rdData` is combinational. It shows the summary bits as they stand before the read's own clear, which takes effect on the next clock edge. `rdData` is 0x00 when the strobe is low or the address is not the summary address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Read address |
| rdStrobe | input | 1 | Read strobe, one cycle per read |
| rdData | output | 8 | Summary read data |
| evtOneSec | input | 1 | One-second event pulse |
| reqHdlc | input | 1 | Data link request pulse |
| reqSlip | input | 1 | Slip buffer request pulse |
| reqAlarm | input | 1 | Alarm and error request pulse |
| reqFrame | input | 1 | Framer status request pulse |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is the collision: a request pulse in exactly the cycle whose read would clear that same bit. Only this case tells a set-wins register from a clear-wins one. Directed sequences create this collision for the summary read and for a sub-block read. A long random phase then drives reads and request pulses together at a high rate, so collisions occur many times on every bit. Throughout, a behavioural model predicts the read data and the interrupt output on every cycle.

// File: rtl/intAggPkg.sv
package intAggPkg;
  localparam int NUM_SRC    = 5;
  localparam int BIT_FRAME  = 0;
  localparam int BIT_ALARM  = 1;
  localparam int BIT_SLIP   = 2;
  localparam int BIT_HDLC   = 3;
  localparam int BIT_ONESEC = 4;

  typedef struct packed {
    logic                sumRead;
    logic [NUM_SRC-1:0]  clr;
  } clrStrobes_t;
endpackage

// File: rtl/intAggCtrl.sv
module intAggCtrl
  import intAggPkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] SUM_ADDR   = 16'h0B00,
  parameter logic [ADDR_W-1:0] HDLC_ADDR  = 16'h0A06,
  parameter logic [ADDR_W-1:0] SLIP_ADDR  = 16'h0A09,
  parameter logic [ADDR_W-1:0] ALARM_ADDR = 16'h0A02,
  parameter logic [ADDR_W-1:0] FRAME_ADDR = 16'h0A04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  output clrStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    strobes.sumRead             = rdStrobe && (addr == SUM_ADDR);
    strobes.clr[BIT_ONESEC]     = strobes.sumRead;
    strobes.clr[BIT_HDLC]       = rdStrobe && (addr == HDLC_ADDR);
    strobes.clr[BIT_SLIP]       = rdStrobe && (addr == SLIP_ADDR);
    strobes.clr[BIT_ALARM]      = rdStrobe && (addr == ALARM_ADDR);
    strobes.clr[BIT_FRAME]      = rdStrobe && (addr == FRAME_ADDR);
  end

  // Sub-block clears never coincide; the summary read clears only bit 4 (R2..R6)
  p_one_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.clr[BIT_HDLC:BIT_FRAME]) && !(strobes.sumRead && |strobes.clr[BIT_HDLC:BIT_FRAME]));
endmodule

// File: rtl/intAggDp.sv
module intAggDp
  import intAggPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  clrStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] evt,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pend;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pend[i] <= 1'b0;
      else       pend[i] <= evt[i] | (pend[i] & ~strobes.clr[i]);
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> pend[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clr[i] && !evt[i]) |=> !pend[i]);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pend[i] && !strobes.clr[i]) |=> pend[i]);
  end

  assign rdData = strobes.sumRead ? {{PAD_W{1'b0}}, pend} : '0;
  assign irqOut = |pend;

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(|strobes.clr));
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: rtl/intStatusAgg.sv
module intStatusAgg
  import intAggPkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] SUM_ADDR   = 16'h0B00,
  parameter logic [ADDR_W-1:0] HDLC_ADDR  = 16'h0A06,
  parameter logic [ADDR_W-1:0] SLIP_ADDR  = 16'h0A09,
  parameter logic [ADDR_W-1:0] ALARM_ADDR = 16'h0A02,
  parameter logic [ADDR_W-1:0] FRAME_ADDR = 16'h0A04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  input  logic              evtOneSec,
  input  logic              reqHdlc,
  input  logic              reqSlip,
  input  logic              reqAlarm,
  input  logic              reqFrame,
  output logic              irqOut
);
  clrStrobes_t        strobes;
  logic [NUM_SRC-1:0] evt;

  always_comb begin
    evt             = '0;
    evt[BIT_ONESEC] = evtOneSec;
    evt[BIT_HDLC]   = reqHdlc;
    evt[BIT_SLIP]   = reqSlip;
    evt[BIT_ALARM]  = reqAlarm;
    evt[BIT_FRAME]  = reqFrame;
  end

  intAggCtrl #(
    .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR), .HDLC_ADDR(HDLC_ADDR),
    .SLIP_ADDR(SLIP_ADDR), .ALARM_ADDR(ALARM_ADDR), .FRAME_ADDR(FRAME_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStrobe(rdStrobe), .strobes(strobes)
  );

  intAggDp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evt(evt),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/intStatusAgg_tb.sv
module intStatusAgg_tb_top;
  localparam logic [15:0] A_SUM   = 16'h0B00;
  localparam logic [15:0] A_HDLC  = 16'h0A06;
  localparam logic [15:0] A_SLIP  = 16'h0A09;
  localparam logic [15:0] A_ALARM = 16'h0A02;
  localparam logic [15:0] A_FRAME = 16'h0A04;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        rdStrobe = 1'b0;
  logic [7:0]  rdData;
  logic        evtOneSec = 0, reqHdlc = 0, reqSlip = 0, reqAlarm = 0, reqFrame = 0;
  logic        irqOut;

  int vecs = 0;
  int errs = 0;
  int model = 0;   // bit i = pending state of source i

  always #5 clk = ~clk;

  intStatusAgg dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStrobe(rdStrobe), .rdData(rdData),
    .evtOneSec(evtOneSec), .reqHdlc(reqHdlc), .reqSlip(reqSlip),
    .reqAlarm(reqAlarm), .reqFrame(reqFrame), .irqOut(irqOut)
  );

  task automatic check(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after negedge, compare, then advance the model at posedge
  task automatic step(string tag, logic [15:0] a, bit rd, int ev);
    int clrMask;
    int expRd;
    @(negedge clk);
    addr = a; rdStrobe = rd;
    evtOneSec = ev[4]; reqHdlc = ev[3]; reqSlip = ev[2]; reqAlarm = ev[1]; reqFrame = ev[0];
    #1;
    expRd = (rd && a == A_SUM) ? model : 0;
    check(tag, "rdData", int'(rdData), expRd);
    check("R7", "rdData[7:5]", int'(rdData[7:5]), 0);
    check("R9", "irqOut", int'(irqOut), (model != 0) ? 1 : 0);
    clrMask = 0;
    if (rd) begin
      if (a == A_SUM)   clrMask = 'h10;
      if (a == A_HDLC)  clrMask = 'h08;
      if (a == A_SLIP)  clrMask = 'h04;
      if (a == A_ALARM) clrMask = 'h02;
      if (a == A_FRAME) clrMask = 'h01;
    end
    @(posedge clk);
    model = (model & ~clrMask) | (ev & 'h1F);
  endtask

  task automatic idle(string tag);
    step(tag, 16'h0000, 1'b0, 0);
  endtask

  task automatic subTest(string tag, int ev, logic [15:0] clrAddr);
    step(tag, 16'h0000, 1'b0, ev);
    step(tag, A_SUM, 1'b1, 0);      // summary read must not clear sub-block bit
    step(tag, A_SUM, 1'b1, 0);
    step(tag, clrAddr, 1'b1, 0);
    step(tag, A_SUM, 1'b1, 0);
    idle(tag);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    @(negedge clk); addr = A_SUM; rdStrobe = 1'b1; #1;
    check("R1", "rdData in reset", int'(rdData), 0);
    check("R1", "irqOut in reset", int'(irqOut), 0);
    @(negedge clk); rstN = 1'b1; rdStrobe = 1'b0;
    step("R1", A_SUM, 1'b1, 0);

    // R2: one-second bit clears on summary read, read shows pre-clear value (R10)
    step("R2", 16'h0000, 1'b0, 'h10);
    step("R2", 16'h0000, 1'b0, 0);
    step("R2", A_SUM, 1'b1, 0);
    step("R2", A_SUM, 1'b1, 0);
    step("R10", A_HDLC, 1'b0, 'h10);
    step("R10", A_SUM, 1'b0, 0);    // strobe low: data 0, no clear
    step("R10", A_SUM, 1'b1, 0);
    idle("R10");

    subTest("R3", 'h08, A_HDLC);
    subTest("R4", 'h04, A_SLIP);
    subTest("R5", 'h02, A_ALARM);
    subTest("R6", 'h01, A_FRAME);

    // R8: event collides with clearing read
    step("R8", 16'h0000, 1'b0, 'h10);
    step("R8", A_SUM, 1'b1, 'h10);
    step("R8", A_SUM, 1'b1, 0);
    step("R8", 16'h0000, 1'b0, 'h08);
    step("R8", A_HDLC, 1'b1, 'h08);
    step("R8", A_SUM, 1'b1, 0);
    step("R8", A_HDLC, 1'b1, 0);

    // R9: irq held until the last bit clears
    step("R9", 16'h0000, 1'b0, 'h1F);
    step("R9", A_FRAME, 1'b1, 0);
    step("R9", A_ALARM, 1'b1, 0);
    step("R9", A_SUM, 1'b1, 0);
    step("R9", A_SLIP, 1'b1, 0);
    step("R9", A_HDLC, 1'b1, 0);
    idle("R9");

    // R10: random mix of reads and events
    for (int n = 0; n < 2000; n++) begin
      int pick;
      logic [15:0] a;
      pick = $urandom_range(0, 6);
      case (pick)
        0: a = A_SUM;   1: a = A_HDLC;  2: a = A_SLIP;
        3: a = A_ALARM; 4: a = A_FRAME; 5: a = A_SUM;
        default: a = 16'h0A00 + 16'($urandom_range(0, 511));
      endcase
      step("R10", a, ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 31)) : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule